// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a single-command SPI master for a serial flash. Software loads an opcode, a count of outgoing payload bytes, a count of bytes to read back and a clock half-period, writes the outgoing payload into a byte buffer, then writes the trigger register with bit 7 set. The engine pulls chip select low, sends the opcode from its own register, sends the payload from the buffer, then clocks in the read bytes. It stores them in the same buffer directly behind the payload and releases chip select. A busy flag covers the whole command, so software polls it before loading the next one.

The engine works in SPI mode 0, most significant bit first. A status word reports the bytes finished so far, the next buffer index the engine reads for transmit, and the next buffer index it writes with received data. A command whose two counts together exceed the buffer is refused and leaves a sticky error bit. Register writes that arrive while a command runs are dropped.

The controller is a six-state machine. `ST_IDLE` goes to `ST_LEAD` on an accepted trigger. `ST_LEAD` waits one SPI clock period with chip select low, then goes to `ST_OPCODE`. When the opcode finishes, the machine goes to `ST_TXDATA` if payload bytes remain, otherwise to `ST_RXDATA` if read bytes remain, otherwise to `ST_TRAIL`. `ST_TXDATA` loops on itself while payload remains, then goes to `ST_RXDATA` or `ST_TRAIL`. `ST_RXDATA` loops on itself while read bytes remain, then goes to `ST_TRAIL`. `ST_TRAIL` holds chip select low for one more SPI period and returns to `ST_IDLE`.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCK is low, and all four status bytes read zero.
- R2: A command sends the opcode register first, then payload bytes from buffer index 0 upward. Each byte goes out most significant bit first.
- R3: Mode 0 timing. SCK idles low. MOSI changes only while SCK is low, and MISO is sampled on the rising SCK edge.
- R4: Read bytes are stored from buffer index equal to the transmit count upward. MOSI sends 0x00 during the read phase.
- R5: Busy (status bit 31) is set from the cycle after an accepted trigger until chip select is released. A trigger write with bit 7 clear starts nothing.
- R6: A trigger whose transmit plus receive count exceeds the buffer depth (71) starts nothing and sets the error bit (status bit 30). The next accepted trigger clears that bit.
- R7: Status layout: bits 7:0 hold the done count, bits 14:8 the engine write index and bits 22:16 the engine read index. After a command these read tx+rx, tx+rx and tx. The opcode is not counted.
- R8: Chip select goes low at least one SPI period before the first rising SCK edge and returns high at least one SPI period after the last falling edge.
- R9: The SCK period is 2*(H+1) system clocks, where H is the half-period register.
- R10: While busy, writes to the opcode, count, half-period, buffer and trigger registers have no effect.
- R11: A command with both counts zero sends exactly one byte, the opcode.
- R12: Bus map (byte offsets): buffer bytes 0x00–0x46, opcode 0x50, trigger 0x51, transmit count 0x52, receive count 0x53, half-period 0x54, and status bytes 0x58–0x5B, least significant byte first. The written registers read back their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe, one cycle per byte |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| spi_sck | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench covers the following corner cases:
- A zero-length command. A design that dropped it would send no opcode.
- A command that fills the 71-byte buffer exactly. A design with an off-by-one limit check would refuse it.
- A 72-byte request. A design that accepted it would start a transfer and leave the error bit clear.
- Register and buffer writes made mid-command. A design that took them would send a corrupted payload or read back changed settings.
- A trigger write without bit 7. A design that ignored the bit would start a transfer.
- Random commands that vary the divider and the counts. A read phase placed at the wrong buffer offset, or a wrong status index or count, would show up here.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_OPCODE,
        ST_TXDATA,
        ST_RXDATA,
        ST_TRAIL
    } eng_state_t;

    typedef struct packed {
        logic       busy;
        logic       err;
        logic [6:0] rsv_hi;
        logic [6:0] rd_idx;
        logic       rsv_mid;
        logic [6:0] wr_idx;
        logic [7:0] done_cnt;
    } eng_status_t;

    localparam int          IDX_W        = 7;
    localparam int          GO_BIT       = 7;
    localparam logic [7:0]  OFS_OPCODE   = 8'h50;
    localparam logic [7:0]  OFS_TRIGGER  = 8'h51;
    localparam logic [7:0]  OFS_TXCNT    = 8'h52;
    localparam logic [7:0]  OFS_RXCNT    = 8'h53;
    localparam logic [7:0]  OFS_HALF     = 8'h54;
    localparam logic [7:0]  OFS_STATUS   = 8'h58;
    localparam logic [7:0]  RX_FILL_BYTE = 8'h00;

endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
    parameter int DEPTH = 71,
    parameter int IW    = 7
) (
    input  logic          clk,
    input  logic          sw_we,
    input  logic [IW-1:0] sw_idx,
    input  logic [7:0]    sw_wdata,
    input  logic          eng_we,
    input  logic [IW-1:0] eng_widx,
    input  logic [7:0]    eng_wdata,
    input  logic [IW-1:0] eng_ridx,
    output logic [7:0]    eng_rdata,
    input  logic [IW-1:0] bus_ridx,
    output logic [7:0]    bus_rdata
);

    logic [7:0] mem [DEPTH];

    // The engine port has priority; the software port is blocked while busy anyway.
    always_ff @(posedge clk) begin
        if (eng_we && (int'(eng_widx) < DEPTH)) begin
            mem[eng_widx] <= eng_wdata;
        end else if (sw_we && (int'(sw_idx) < DEPTH)) begin
            mem[sw_idx] <= sw_wdata;
        end
    end

    assign eng_rdata = (int'(eng_ridx) < DEPTH) ? mem[eng_ridx] : 8'h00;
    assign bus_rdata = (int'(bus_ridx) < DEPTH) ? mem[bus_ridx] : 8'h00;

endmodule

// File: rtl/spi_cmd_tick.sv
module spi_cmd_tick #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] half,
    output logic            tick
);

    logic [DIVW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || (cnt_q == half)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == half);

endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);

    logic [7:0] tx_sr;
    logic [7:0] rx_sr;
    logic [2:0] bit_idx;
    logic       act;
    logic       sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            bit_idx <= '0;
            act     <= 1'b0;
            sck_q   <= 1'b0;
        end else if (start) begin
            tx_sr   <= tx_byte;
            bit_idx <= '0;
            act     <= 1'b1;
            sck_q   <= 1'b0;
        end else if (act && tick) begin
            if (!sck_q) begin
                sck_q <= 1'b1;
                rx_sr <= {rx_sr[6:0], miso};
            end else begin
                sck_q <= 1'b0;
                if (bit_idx == 3'd7) begin
                    act <= 1'b0;
                end else begin
                    bit_idx <= bit_idx + 3'd1;
                    tx_sr   <= {tx_sr[6:0], 1'b0};
                end
            end
        end
    end

    assign done    = act && tick && sck_q && (bit_idx == 3'd7);
    assign sck     = sck_q;
    assign mosi    = tx_sr[7];
    assign rx_byte = rx_sr;

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
    parameter int DEPTH = 71,
    parameter int DIVW  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       spi_sck,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    import spi_cmd_pkg::*;

    localparam int IW = IDX_W;
    localparam int SW = 9;

    eng_state_t      state_q, state_d;
    logic [7:0]      opcode_q, txcnt_q, rxcnt_q;
    logic [DIVW-1:0] half_q;
    logic            err_q, pace_q;
    logic [7:0]      done_q, tx_left_q, rx_left_q;
    logic [IW-1:0]   rd_ptr_q, wr_ptr_q;

    logic            busy, sw_acc, go_wr, fits, launch, reject;
    logic            tick, sh_start, sh_done, rx_store;
    logic [7:0]      sh_byte, sh_rx, fifo_tx, fifo_bus;
    eng_status_t     stat;

    assign busy   = (state_q != ST_IDLE);
    assign sw_acc = bus_we && !busy;
    assign go_wr  = sw_acc && (bus_addr == OFS_TRIGGER) && bus_wdata[GO_BIT];
    assign fits   = (({1'b0, txcnt_q} + {1'b0, rxcnt_q}) <= SW'(DEPTH));
    assign launch = go_wr && fits;
    assign reject = go_wr && !fits;

    spi_cmd_tick #(.DIVW(DIVW)) u_tick (
        .clk (clk),
        .rst_n (rst_n),
        .run (busy),
        .half (half_q),
        .tick (tick)
    );

    spi_cmd_shift u_shift (
        .clk (clk),
        .rst_n (rst_n),
        .start (sh_start),
        .tx_byte (sh_byte),
        .tick (tick),
        .miso (spi_miso),
        .sck (spi_sck),
        .mosi (spi_mosi),
        .done (sh_done),
        .rx_byte (sh_rx)
    );

    spi_cmd_fifo #(.DEPTH(DEPTH), .IW(IW)) u_fifo (
        .clk (clk),
        .sw_we (sw_acc && (int'(bus_addr) < DEPTH)),
        .sw_idx (bus_addr[IW-1:0]),
        .sw_wdata (bus_wdata),
        .eng_we (rx_store),
        .eng_widx (wr_ptr_q),
        .eng_wdata (sh_rx),
        .eng_ridx (rd_ptr_q),
        .eng_rdata (fifo_tx),
        .bus_ridx (bus_addr[IW-1:0]),
        .bus_rdata (fifo_bus)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pace_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q != state_d) begin
                pace_q <= 1'b0;
            end else if (tick) begin
                pace_q <= ~pace_q;
            end
        end
    end

    // Next state and byte launch
    always_comb begin
        state_d  = state_q;
        sh_start = 1'b0;
        sh_byte  = RX_FILL_BYTE;
        rx_store = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (launch) state_d = ST_LEAD;
            end
            ST_LEAD: begin
                if (tick && pace_q) begin
                    sh_start = 1'b1;
                    sh_byte  = opcode_q;
                    state_d  = ST_OPCODE;
                end
            end
            ST_OPCODE, ST_TXDATA, ST_RXDATA: begin
                if (sh_done) begin
                    rx_store = (state_q == ST_RXDATA);
                    if (tx_left_q != 8'd0) begin
                        sh_start = 1'b1;
                        sh_byte  = fifo_tx;
                        state_d  = ST_TXDATA;
                    end else if (rx_left_q != 8'd0) begin
                        sh_start = 1'b1;
                        sh_byte  = RX_FILL_BYTE;
                        state_d  = ST_RXDATA;
                    end else begin
                        state_d  = ST_TRAIL;
                    end
                end
            end
            ST_TRAIL: begin
                if (tick && pace_q) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs from state
    always_comb begin
        spi_cs_n = (state_q == ST_IDLE);
    end

    // Software-visible registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opcode_q <= '0;
            txcnt_q  <= '0;
            rxcnt_q  <= '0;
            half_q   <= '0;
            err_q    <= 1'b0;
        end else begin
            if (sw_acc) begin
                case (bus_addr)
                    OFS_OPCODE: opcode_q <= bus_wdata;
                    OFS_TXCNT:  txcnt_q  <= bus_wdata;
                    OFS_RXCNT:  rxcnt_q  <= bus_wdata;
                    OFS_HALF:   half_q   <= bus_wdata[DIVW-1:0];
                    default: ;
                endcase
            end
            if (reject) begin
                err_q <= 1'b1;
            end else if (launch) begin
                err_q <= 1'b0;
            end
        end
    end

    // Engine progress counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_left_q <= '0;
            rx_left_q <= '0;
            rd_ptr_q  <= '0;
            wr_ptr_q  <= '0;
            done_q    <= '0;
        end else if (launch) begin
            tx_left_q <= txcnt_q;
            rx_left_q <= rxcnt_q;
            rd_ptr_q  <= '0;
            wr_ptr_q  <= txcnt_q[IW-1:0];
            done_q    <= '0;
        end else begin
            if (sh_start && (state_d == ST_TXDATA)) begin
                tx_left_q <= tx_left_q - 8'd1;
                rd_ptr_q  <= rd_ptr_q + 1'b1;
            end
            if (sh_start && (state_d == ST_RXDATA)) begin
                rx_left_q <= rx_left_q - 8'd1;
            end
            if (rx_store) begin
                wr_ptr_q <= wr_ptr_q + 1'b1;
            end
            if (sh_done && ((state_q == ST_TXDATA) || (state_q == ST_RXDATA))) begin
                done_q <= done_q + 8'd1;
            end
        end
    end

    // Read mux
    always_comb begin
        stat          = '0;
        stat.busy     = busy;
        stat.err      = err_q;
        stat.rd_idx   = rd_ptr_q;
        stat.wr_idx   = wr_ptr_q;
        stat.done_cnt = done_q;
        if (int'(bus_addr) < DEPTH) begin
            bus_rdata = fifo_bus;
        end else begin
            case (bus_addr)
                OFS_OPCODE:       bus_rdata = opcode_q;
                OFS_TXCNT:        bus_rdata = txcnt_q;
                OFS_RXCNT:        bus_rdata = rxcnt_q;
                OFS_HALF:         bus_rdata = 8'(half_q);
                OFS_STATUS:       bus_rdata = stat[7:0];
                OFS_STATUS + 8'd1: bus_rdata = stat[15:8];
                OFS_STATUS + 8'd2: bus_rdata = stat[23:16];
                OFS_STATUS + 8'd3: bus_rdata = stat[31:24];
                default:          bus_rdata = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
    parameter int DEPTH = 71
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       cs_n,
    input logic       sck,
    input logic       err,
    input logic       go,
    input logic       fits,
    input logic [7:0] opcode,
    input logic [7:0] txcnt,
    input logic [6:0] wr_ptr,
    input logic [7:0] done_cnt
);

    // R3: the serial clock idles low whenever chip select is released
    a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    // R6: a refused trigger never starts a command
    a_r6_reject_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !fits) |=> !busy);

    // R6: the error bit rises only after an oversize trigger
    a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(go && !fits));

    // R10: settings are frozen during a command
    a_r10_opcode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(opcode) && $stable(txcnt)));

    // R7: the engine write index never passes the buffer end
    a_r7_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wr_ptr) <= DEPTH);

    // R7: the done count only grows within a command
    a_r7_done_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (done_cnt >= $past(done_cnt)));

endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.DEPTH(DEPTH)) u_chk (
    .clk (clk),
    .rst_n (rst_n),
    .busy (busy),
    .cs_n (spi_cs_n),
    .sck (spi_sck),
    .err (err_q),
    .go (go_wr),
    .fits (fits),
    .opcode (opcode_q),
    .txcnt (txcnt_q),
    .wr_ptr (wr_ptr_q),
    .done_cnt (done_q)
);

// File: tb/test_spi_cmd_engine.sv
module test_spi_cmd_engine;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 71;
    localparam logic [7:0] A_OPC = 8'h50, A_TRIG = 8'h51, A_TX = 8'h52,
                           A_RX = 8'h53, A_HALF = 8'h54, A_ST = 8'h58;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       spi_sck, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;

    spi_cmd_engine #(.DEPTH(DEPTH)) i_spi_cmd_engine (
        .clk (clk), .rst_n (rst_n), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .spi_sck (spi_sck),
        .spi_cs_n (spi_cs_n), .spi_mosi (spi_mosi), .spi_miso (spi_miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Flash model: answers every byte position with a computed byte
    logic [7:0] salt = 8'h00;
    int s_pos = 0, s_bit = 0, s_nbits = 0, ncap = 0;
    logic [7:0] s_sh = 8'h00;
    logic [7:0] capt [128];

    function automatic logic [7:0] resp_byte(int pos, logic [7:0] s);
        return 8'(pos * 59) ^ s;
    endfunction

    function automatic logic resp_bit(int pos, int b, logic [7:0] s);
        logic [7:0] v;
        v = resp_byte(pos, s);
        return v[7 - b];
    endfunction

    always @(negedge spi_cs_n) begin
        s_pos = 0; s_bit = 0; s_nbits = 0;
        spi_miso = resp_bit(0, 0, salt);
    end

    always @(posedge spi_sck) if (!spi_cs_n) begin
        s_sh = {s_sh[6:0], spi_mosi};
        s_nbits++;
        if (s_nbits == 8) begin
            if (ncap < 128) capt[ncap] = s_sh;
            ncap++;
            s_nbits = 0;
        end
    end

    always @(negedge spi_sck) if (!spi_cs_n) begin
        s_bit++;
        if (s_bit == 8) begin s_bit = 0; s_pos++; end
        spi_miso = resp_bit(s_pos, s_bit, salt);
    end

    // Timing observer, sampled away from the active edge
    logic prev_cs = 1'b1, prev_sck = 1'b0, prev_mosi = 1'b0;
    int t_csf = 0, t_csr = 0, t_r1 = 0, t_r2 = 0, t_lf = 0, nrise = 0, n_csf = 0, mosi_bad = 0;
    always @(negedge clk) begin
        if (prev_cs && !spi_cs_n) begin t_csf = cyc; nrise = 0; n_csf++; end
        if (!prev_cs && spi_cs_n) t_csr = cyc;
        if (!prev_sck && spi_sck) begin
            nrise++;
            if (nrise == 1) t_r1 = cyc;
            if (nrise == 2) t_r2 = cyc;
        end
        if (prev_sck && !spi_sck) t_lf = cyc;
        if (prev_sck && spi_sck && (spi_mosi !== prev_mosi)) mosi_bad++;
        prev_cs = spi_cs_n; prev_sck = spi_sck; prev_mosi = spi_mosi;
    end

    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic read_status(output logic [31:0] s);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            bus_read(A_ST + 8'(i), b);
            s[8*i +: 8] = b;
        end
    endtask

    task automatic wait_idle();
        logic [7:0] b;
        for (int i = 0; i < 20000; i++) begin
            bus_read(A_ST + 8'd3, b);
            if (!b[7]) break;
        end
    endtask

    task automatic run_cmd(logic [7:0] op, int tx, int rx, int half, logic [7:0] sl, bit poke);
        logic [7:0] txd [DEPTH];
        logic [7:0] b;
        logic [31:0] st;
        salt = sl; ncap = 0; mosi_bad = 0;
        for (int i = 0; i < tx; i++) begin
            txd[i] = 8'($urandom);
            bus_write(8'(i), txd[i]);
        end
        bus_write(A_OPC, op);
        bus_write(A_TX, 8'(tx));
        bus_write(A_RX, 8'(rx));
        bus_write(A_HALF, 8'(half));
        bus_write(A_TRIG, 8'h80);
        bus_read(A_ST + 8'd3, b);
        check("R5 busy after trigger", int'(b[7]), 1);
        if (poke) begin
            // R10: these writes land mid-command and must be dropped
            bus_write(A_OPC, ~op);
            bus_write(A_RX, 8'(rx + 3));
            bus_write(A_HALF, 8'(half + 1));
            bus_write(8'h00, ~txd[0]);
            bus_write(A_TRIG, 8'h80);
        end
        wait_idle();
        check("R2 byte count", ncap, 1 + tx + rx);
        check("R2 opcode first", int'(capt[0]), int'(op));
        for (int i = 0; i < tx; i++) check("R2 tx byte", int'(capt[1 + i]), int'(txd[i]));
        for (int k = 0; k < rx; k++) begin
            check("R4 fill byte", int'(capt[1 + tx + k]), 0);
            bus_read(8'(tx + k), b);
            check("R4 rx stored", int'(b), int'(resp_byte(1 + tx + k, sl)));
        end
        read_status(st);
        check("R7 done count", int'(st[7:0]), tx + rx);
        check("R7 write index", int'(st[14:8]), tx + rx);
        check("R7 read index", int'(st[22:16]), tx);
        check("R5 busy clear", int'(st[31]), 0);
        check("R6 error clear", int'(st[30]), 0);
        check("R9 sck period", t_r2 - t_r1, 2 * (half + 1));
        check("R8 cs lead", int'((t_r1 - t_csf) >= 2 * (half + 1)), 1);
        check("R8 cs trail", int'((t_csr - t_lf) >= 2 * (half + 1)), 1);
        check("R3 mosi stable while sck high", mosi_bad, 0);
        if (poke) begin
            bus_read(A_OPC, b);  check("R10 opcode kept", int'(b), int'(op));
            bus_read(A_RX, b);   check("R10 rx count kept", int'(b), rx);
            bus_read(A_HALF, b); check("R10 half kept", int'(b), half);
            bus_read(8'h00, b);  check("R10 buffer kept", int'(b), int'(txd[0]));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] st;
        logic [7:0]  b;
        int          csf0;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 cs_n high", int'(spi_cs_n), 1);
        check("R1 sck low", int'(spi_sck), 0);
        read_status(st);
        check("R1 status zero", int'(st), 0);

        // R12 register readback
        bus_write(A_HALF, 8'h03);
        bus_read(A_HALF, b);
        check("R12 half readback", int'(b), 3);
        bus_write(A_TX, 8'h05);
        bus_read(A_TX, b);
        check("R12 tx count readback", int'(b), 5);

        // R11 opcode only
        run_cmd(8'h9F, 0, 0, 0, 8'h11, 1'b0);

        // R5 trigger without bit 7
        csf0 = n_csf;
        bus_write(A_TX, 8'd2);
        bus_write(A_RX, 8'd2);
        bus_write(A_TRIG, 8'h7F);
        repeat (20) @(negedge clk);
        read_status(st);
        check("R5 no start without bit 7", int'(st[31]), 0);
        check("R5 cs untouched", n_csf - csf0, 0);

        // R6 oversize request
        bus_write(A_TX, 8'd40);
        bus_write(A_RX, 8'd32);
        bus_write(A_TRIG, 8'h80);
        repeat (20) @(negedge clk);
        read_status(st);
        check("R6 error set", int'(st[30]), 1);
        check("R6 not busy", int'(st[31]), 0);
        check("R6 no chip select", n_csf - csf0, 0);

        // R6 full-depth boundary is accepted and clears the error
        run_cmd(8'h0B, 30, 41, 0, 8'h5C, 1'b0);

        // R10 writes during busy
        run_cmd(8'h03, 3, 2, 2, 8'hA7, 1'b1);

        // Random commands
        for (int n = 0; n < 6; n++) begin
            run_cmd(8'($urandom), int'($urandom_range(0, 8)), int'($urandom_range(0, 8)),
                    int'($urandom_range(0, 3)), 8'($urandom), 1'b0);
        end

        check("R3 sck idle low", int'(spi_sck), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule